// File: doc/BRIEF.md
# Infrared Link Mode Control Register

This block is the host-side control register of a serial infrared link engine, together with the sequencing logic around it. The host writes one byte to choose the link direction (off, transmit or receive) and to request abort, data-done marking, the periodic interaction pulse, back-to-back framing and loopback. From that state the block drives the transmitter and receiver enables, and two select lines that set which way the data FIFO faces.

Hardware events also change the register. Terminal count marks the end of valid transmit data. An accepted abort raises an abort-sequence request, forces end-of-message and clears the FIFO. In consumer-IR operation the direction field clears itself when a frame ends after an underrun, or after terminal count when receiving. In fast-IR operation the direction field changes only when the host writes it.

A read always shows the live register. This includes bits that hardware has already cleared.

Top module: `irlink_modectl`

## Requirements
- R1: After reset the register reads 0x00, and tx_en, rx_en, abort_req, eom_force, fifo_clr, pulse_stb, loop_en and btb_run are all low.
- R2: Register bits 7:6 hold the direction: 01 transmit, 10 receive, 00 and 11 both disabled. fifo_dir_tx is high only for 01. fifo_dir_rx and rx_en are high only for 10. The value 11 reads back unchanged.
- R3: In transmit mode tx_en stays low until terminal count or the FIFO-above-threshold input is seen. It rises one cycle after that and holds until the direction field leaves 01.
- R4: With fast_mode low, a direction of 01 clears to 00 on the first rising edge of frame_act_n after a FIFO underrun. A rising edge that has no prior underrun leaves the field unchanged.
- R5: With fast_mode low, a direction of 10 clears to 00 on the first rising edge of frame_act_n after either a FIFO underrun or terminal count.
- R6: With fast_mode high, only a host write changes bits 7:6. Underrun, terminal count and frame edges do not.
- R7: In fast-IR transmit, writing bit 2 as 1 has these effects. Bit 2 reads 1, and abort_req and eom_force go high, all until eom_in is seen. fifo_clr pulses for exactly one cycle.
- R8: A bit-2 write in consumer mode, or with a direction other than 01, is ignored. Bit 2 reads 0 and fifo_clr stays low.
- R9: Terminal count sets bit 1 (data done) while the direction is 01. It never sets bit 1 while the direction is 10.
- R10: Bit 1 clears on eom_in only while fifo_empty is high. Otherwise it holds.
- R11: With bit 5 set, fast_mode high, no transmit or receive enable, and frame_act_n high, pulse_stb fires for one cycle every PULSE_CYC cycles.
- R12: The pulse interval restarts from zero whenever the link becomes busy. No strobe fires while fast_mode is low.
- R13: Bit 3 (loopback) is accepted only when the written direction is 00. loop_en follows bit 3.
- R14: With bit 4 set, direction 01 and fast_mode high, btb_run is high and btb_gap equals btb_flags. In every other case btb_run is low and btb_gap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Live register contents |
| fast_mode | input | 1 | 1 selects fast-IR, 0 selects consumer-IR |
| tc | input | 1 | DMA terminal count |
| fifo_empty | input | 1 | FIFO empty status |
| fifo_underrun | input | 1 | FIFO underrun event |
| fifo_over_thr | input | 1 | FIFO fill level above threshold |
| frame_act_n | input | 1 | Frame active, active low |
| eom_in | input | 1 | End of message from the link engine |
| btb_flags | input | FLAG_W | Extra flag count between back-to-back frames |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| abort_req | output | 1 | Request to send the abort sequence |
| eom_force | output | 1 | Forced end-of-message |
| fifo_clr | output | 1 | One-cycle FIFO clear |
| fifo_dir_tx | output | 1 | FIFO faces host to transmitter |
| fifo_dir_rx | output | 1 | FIFO faces receiver to host |
| pulse_stb | output | 1 | Interaction pulse strobe |
| loop_en | output | 1 | Loopback enabled |
| btb_run | output | 1 | Back-to-back framing active |
| btb_gap | output | FLAG_W | Extra flags to insert between frames |

## Verification
The bench builds the block with PULSE_CYC set to 16 and FLAG_W left at 4. At that setting the interaction-pulse interval, the gap between two strobes, and the restart after a busy frame can each be counted cycle by cycle within a short run. The default of twenty-five million cycles is far too long to reach. A four-bit flag count is enough to show that btb_gap passes the value through and that it is forced to zero.

// File: rtl/irlink_pkg.sv
package irlink_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_TX  = 2'b01,
    MODE_RX  = 2'b10,
    MODE_BAD = 2'b11
  } irl_mode_e;

  typedef struct packed {
    irl_mode_e mode;
    logic      pulse_en;
    logic      btb_en;
    logic      loop_en;
    logic      abort;
    logic      done;
  } irl_ctl_t;

  function automatic logic irl_is_tx(irl_mode_e m);
    return m == MODE_TX;
  endfunction

  function automatic logic irl_is_rx(irl_mode_e m);
    return m == MODE_RX;
  endfunction

  function automatic logic [7:0] irl_pack(irl_ctl_t c);
    return {c.mode, c.pulse_en, c.btb_en, c.loop_en, c.abort, c.done, 1'b0};
  endfunction

endpackage

// File: rtl/irlink_ctlreg.sv
module irlink_ctlreg
  import irlink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fast_mode,
  input  logic       tc,
  input  logic       fifo_empty,
  input  logic       fifo_underrun,
  input  logic       frame_rise,
  input  logic       eom_in,
  output irl_ctl_t   ctl,
  output logic       abort_acc,
  output logic       tx_autoclr,
  output logic       rx_autoclr
);

  irl_mode_e wr_mode;
  logic      tx_arm;
  logic      rx_arm;
  logic      is_tx;
  logic      is_rx;

  assign wr_mode    = irl_mode_e'(wr_data[7:6]);
  assign is_tx      = irl_is_tx(ctl.mode);
  assign is_rx      = irl_is_rx(ctl.mode);
  assign abort_acc  = wr_en & wr_data[2] & fast_mode & irl_is_tx(wr_mode);
  assign tx_autoclr = ~fast_mode & frame_rise & tx_arm & is_tx;
  assign rx_autoclr = ~fast_mode & frame_rise & rx_arm & is_rx;

  // arm flags remember an underrun / terminal count until the frame ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_arm <= 1'b0;
      rx_arm <= 1'b0;
    end else begin
      if (wr_en || !is_tx || tx_autoclr)        tx_arm <= 1'b0;
      else if (!fast_mode && fifo_underrun)     tx_arm <= 1'b1;

      if (wr_en || !is_rx || rx_autoclr)        rx_arm <= 1'b0;
      else if (!fast_mode && (fifo_underrun || tc)) rx_arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.mode     <= wr_mode;
      ctl.pulse_en <= wr_data[5];
      ctl.btb_en   <= wr_data[4];
      ctl.loop_en  <= wr_data[3] & (wr_mode == MODE_OFF);
      ctl.abort    <= ctl.abort | abort_acc;
      ctl.done     <= wr_data[1];
    end else begin
      if (tx_autoclr || rx_autoclr) ctl.mode <= MODE_OFF;
      if (eom_in) ctl.abort <= 1'b0;
      if (tc && is_tx)                ctl.done <= 1'b1;
      else if (eom_in && fifo_empty)  ctl.done <= 1'b0;
    end
  end

endmodule

// File: rtl/irlink_steer.sv
module irlink_steer
  import irlink_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irl_ctl_t          ctl,
  input  logic              fast_mode,
  input  logic              tc,
  input  logic              fifo_over_thr,
  input  logic [FLAG_W-1:0] btb_flags,
  output logic              tx_en,
  output logic              rx_en,
  output logic              fifo_dir_tx,
  output logic              fifo_dir_rx,
  output logic              btb_run,
  output logic [FLAG_W-1:0] btb_gap
);

  logic tx_go;
  logic is_tx;

  assign is_tx = irl_is_tx(ctl.mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tx_go <= 1'b0;
    else if (!is_tx)              tx_go <= 1'b0;
    else if (tc || fifo_over_thr) tx_go <= 1'b1;
  end

  assign tx_en       = is_tx & tx_go;
  assign rx_en       = irl_is_rx(ctl.mode);
  assign fifo_dir_tx = is_tx;
  assign fifo_dir_rx = irl_is_rx(ctl.mode);
  assign btb_run     = ctl.btb_en & fast_mode & is_tx;
  assign btb_gap     = btb_run ? btb_flags : '0;

endmodule

// File: rtl/irlink_pulse_timer.sv
module irlink_pulse_timer #(
  parameter int PULSE_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic stb
);

  localparam int CW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt;

  function automatic logic at_last(logic [CW-1:0] c);
    return c == LAST;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      stb <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      stb <= 1'b0;
    end else if (at_last(cnt)) begin
      cnt <= '0;
      stb <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      stb <= 1'b0;
    end
  end

endmodule

// File: rtl/irlink_modectl.sv
module irlink_modectl
  import irlink_pkg::*;
#(
  parameter int PULSE_CYC = 25_000_000,
  parameter int FLAG_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              fast_mode,
  input  logic              tc,
  input  logic              fifo_empty,
  input  logic              fifo_underrun,
  input  logic              fifo_over_thr,
  input  logic              frame_act_n,
  input  logic              eom_in,
  input  logic [FLAG_W-1:0] btb_flags,
  output logic              tx_en,
  output logic              rx_en,
  output logic              abort_req,
  output logic              eom_force,
  output logic              fifo_clr,
  output logic              fifo_dir_tx,
  output logic              fifo_dir_rx,
  output logic              pulse_stb,
  output logic              loop_en,
  output logic              btb_run,
  output logic [FLAG_W-1:0] btb_gap
);

  irl_ctl_t ctl;
  logic     frame_q;
  logic     frame_rise;
  logic     abort_acc;
  logic     tx_autoclr;
  logic     rx_autoclr;
  logic     link_idle;
  logic     pulse_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= 1'b1;
      fifo_clr <= 1'b0;
    end else begin
      frame_q  <= frame_act_n;
      fifo_clr <= abort_acc;
    end
  end

  assign frame_rise = frame_act_n & ~frame_q;

  irlink_ctlreg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .fast_mode    (fast_mode),
    .tc           (tc),
    .fifo_empty   (fifo_empty),
    .fifo_underrun(fifo_underrun),
    .frame_rise   (frame_rise),
    .eom_in       (eom_in),
    .ctl          (ctl),
    .abort_acc    (abort_acc),
    .tx_autoclr   (tx_autoclr),
    .rx_autoclr   (rx_autoclr)
  );

  irlink_steer #(.FLAG_W(FLAG_W)) u_steer (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .fast_mode    (fast_mode),
    .tc           (tc),
    .fifo_over_thr(fifo_over_thr),
    .btb_flags    (btb_flags),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .fifo_dir_tx  (fifo_dir_tx),
    .fifo_dir_rx  (fifo_dir_rx),
    .btb_run      (btb_run),
    .btb_gap      (btb_gap)
  );

  assign link_idle = ~tx_en & ~rx_en & frame_act_n;
  assign pulse_run = ctl.pulse_en & fast_mode & link_idle;

  irlink_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (pulse_run),
    .stb  (pulse_stb)
  );

  assign rd_data   = irl_pack(ctl);
  assign abort_req = ctl.abort;
  assign eom_force = ctl.abort;
  assign loop_en   = ctl.loop_en;

endmodule

// File: rtl/irlink_modectl_chk.sv
module irlink_modectl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       fast_mode,
  input logic [7:0] rd_data,
  input logic       tx_en,
  input logic       rx_en,
  input logic       fifo_clr,
  input logic       pulse_stb,
  input logic       loop_en,
  input logic       frame_rise
);

  p_rx_en_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> rd_data[7:6] == 2'b10);

  p_tx_en_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> rd_data[7:6] == 2'b01);

  p_autoclr_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !fast_mode && !frame_rise) |=> rd_data[7:6] == $past(rd_data[7:6]));

  p_fast_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && fast_mode) |=> rd_data[7:6] == $past(rd_data[7:6]));

  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !fifo_clr);

  p_abort_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> ($past(fast_mode) && rd_data[7:6] == 2'b01));

  p_done_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[7:6] == 2'b10 && !rd_data[1]) |=> !rd_data[1]);

  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_stb |=> !pulse_stb);

  p_stb_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_stb |-> $past(rd_data[5] && fast_mode));

  p_loop_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> rd_data[7:6] == 2'b00);

endmodule

bind irlink_modectl irlink_modectl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .fast_mode (fast_mode),
  .rd_data   (rd_data),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .fifo_clr  (fifo_clr),
  .pulse_stb (pulse_stb),
  .loop_en   (loop_en),
  .frame_rise(frame_rise)
);

// File: tb/tb_irlink_modectl.sv
module tb_irlink_modectl;

  localparam int N  = 16;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic fast_mode = 1'b1;
  logic tc = 1'b0, fifo_empty = 1'b1, fifo_underrun = 1'b0, fifo_over_thr = 1'b0;
  logic frame_act_n = 1'b1, eom_in = 1'b0;
  logic [FW-1:0] btb_flags = '0;
  logic tx_en, rx_en, abort_req, eom_force, fifo_clr, fifo_dir_tx, fifo_dir_rx;
  logic pulse_stb, loop_en, btb_run;
  logic [FW-1:0] btb_gap;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  irlink_modectl #(.PULSE_CYC(N), .FLAG_W(FW)) dut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic pulse_in(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic frame_end();
    frame_act_n = 1'b0; tick(); frame_act_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    chk(rd_data, 8'h00, "R1 reg");
    chk({tx_en, rx_en, abort_req, eom_force, fifo_clr, pulse_stb, loop_en, btb_run}, 0, "R1 outs");
  endtask

  task automatic t_modes();
    fast_mode = 1'b1;
    wr(8'h40);
    chk({fifo_dir_tx, fifo_dir_rx, rx_en}, 3'b100, "R2 tx dir");
    wr(8'h80);
    chk({fifo_dir_tx, fifo_dir_rx, rx_en}, 3'b011, "R2 rx dir");
    wr(8'hC0);
    chk(rd_data, 8'hC0, "R2 undef readback");
    chk({fifo_dir_tx, fifo_dir_rx, rx_en, tx_en}, 0, "R2 undef off");
    wr(8'h00);
  endtask

  task automatic t_txen();
    wr(8'h40); tick(); tick();
    chk(tx_en, 0, "R3 no trigger");
    pulse_in(fifo_over_thr);
    chk(tx_en, 1, "R3 threshold");
    tick();
    chk(tx_en, 1, "R3 holds");
    wr(8'h00);
    chk(tx_en, 0, "R3 leave tx");
    wr(8'h40);
    pulse_in(tc);
    chk(tx_en, 1, "R3 tc");
    chk(rd_data, 8'h42, "R9 tc sets done in tx");
    wr(8'h00);
  endtask

  task automatic t_consumer();
    fast_mode = 1'b0;
    wr(8'h40);
    frame_end();
    chk(rd_data, 8'h40, "R4 no underrun keeps tx");
    pulse_in(fifo_underrun);
    frame_end();
    chk(rd_data, 8'h00, "R4 underrun then edge clears tx");
    wr(8'h80);
    pulse_in(tc);
    chk(rd_data, 8'h80, "R9 tc no done in rx");
    frame_end();
    chk(rd_data, 8'h00, "R5 tc then edge clears rx");
    wr(8'h80);
    pulse_in(fifo_underrun);
    frame_end();
    chk(rd_data, 8'h00, "R5 underrun then edge clears rx");
  endtask

  task automatic t_fast_hold();
    fast_mode = 1'b1;
    wr(8'h40);
    pulse_in(fifo_underrun);
    frame_end();
    chk(rd_data[7:6], 2'b01, "R6 tx held");
    wr(8'h80);
    pulse_in(tc);
    pulse_in(fifo_underrun);
    frame_end();
    chk(rd_data[7:6], 2'b10, "R6 rx held");
    wr(8'h00);
  endtask

  task automatic t_abort();
    fast_mode = 1'b1;
    wr(8'h40);
    wr(8'h44);
    chk({rd_data[2], abort_req, eom_force, fifo_clr}, 4'b1111, "R7 abort accepted");
    tick();
    chk({abort_req, fifo_clr}, 2'b10, "R7 clear single cycle");
    pulse_in(eom_in);
    chk({rd_data, abort_req, eom_force}, {8'h40, 2'b00}, "R7 cleared by eom");
    fast_mode = 1'b0;
    wr(8'h44);
    chk({rd_data[2], fifo_clr, abort_req}, 0, "R8 consumer ignored");
    fast_mode = 1'b1;
    wr(8'h84);
    chk({rd_data, fifo_clr}, {8'h80, 1'b0}, "R8 rx ignored");
    wr(8'h00);
  endtask

  task automatic t_done();
    fast_mode = 1'b1;
    fifo_empty = 1'b0;
    wr(8'h40);
    pulse_in(tc);
    chk(rd_data, 8'h42, "R9 done set");
    pulse_in(eom_in);
    chk(rd_data, 8'h42, "R10 held while fifo not empty");
    fifo_empty = 1'b1;
    pulse_in(eom_in);
    chk(rd_data, 8'h40, "R10 cleared when empty");
    wr(8'h00);
  endtask

  task automatic t_pulse();
    int first, gap, again;
    bit seen;
    fast_mode = 1'b1;
    wr(8'h20);
    first = 0; seen = 0;
    for (int i = 1; i <= 3*N && !seen; i++) begin
      tick();
      if (pulse_stb) begin first = i; seen = 1; end
    end
    chk(first, N, "R11 first interval");
    gap = 0; seen = 0;
    for (int i = 1; i <= 3*N && !seen; i++) begin
      tick();
      if (pulse_stb) begin gap = i; seen = 1; end
    end
    chk(gap, N, "R11 repeat interval");
    repeat (5) tick();
    frame_act_n = 1'b0;
    repeat (3) tick();
    frame_act_n = 1'b1;
    again = 0; seen = 0;
    for (int i = 1; i <= 3*N && !seen; i++) begin
      tick();
      if (pulse_stb) begin again = i; seen = 1; end
    end
    chk(again, N, "R12 restart after busy");
    fast_mode = 1'b0;
    seen = 0;
    for (int i = 0; i < 3*N; i++) begin
      tick();
      if (pulse_stb) seen = 1;
    end
    chk(seen, 0, "R12 none in consumer mode");
    fast_mode = 1'b1;
    wr(8'h00);
  endtask

  task automatic t_loop();
    wr(8'h08);
    chk({rd_data, loop_en}, {8'h08, 1'b1}, "R13 loop accepted");
    wr(8'h48);
    chk({rd_data, loop_en}, {8'h40, 1'b0}, "R13 loop rejected");
    wr(8'h00);
  endtask

  task automatic t_btb();
    fast_mode = 1'b1;
    btb_flags = 4'd5;
    wr(8'h50);
    chk({btb_run, btb_gap}, {1'b1, 4'd5}, "R14 active");
    fast_mode = 1'b0; #1;
    chk({btb_run, btb_gap}, 0, "R14 consumer off");
    fast_mode = 1'b1;
    wr(8'h10);
    chk({btb_run, btb_gap}, 0, "R14 mode off");
    wr(8'h00);
  endtask

  initial begin
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_modes();
    t_txen();
    t_consumer();
    t_fast_hold();
    t_abort();
    t_done();
    t_pulse();
    t_loop();
    t_btb();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule